// File: doc/BRIEF.md
# Fetch address trap controller

The block watches the instruction-fetch bus of a small CPU and flags code fetched from memory that is meant to hold data only. Three address windows are defined at build time: the special-function register window, the debug register window and the data RAM window. An opcode fetch that lands in the special-function or debug window always raises a trap. A fetch from data RAM raises a trap only while the committed RAM-trap enable is set.

Software controls the block through two write-only byte registers. The control register holds a staged RAM-trap enable in bit 7 and the trap action in bit 6. A staged enable does not take effect when it is written. It becomes live only when the command register is later written with the commit key. The command register also takes the two key bytes that produce one-cycle clear and disable strobes for a companion watchdog counter. Every other byte written there is discarded.

A trap appears as a one-cycle pulse, either on the non-maskable interrupt request or on the reset request. The action bit picks which one. Nothing masks or holds back a trap pulse: each trapping fetch gives its own pulse, even when another trap was just signalled.

Top module: `fetch_trap_ctrl`

## Requirements
- R1: After reset all four outputs are low, the committed RAM-trap enable is 1 and the action is interrupt, so the first RAM opcode fetch produces an `irq_trap_o` pulse.
- R2: An opcode fetch whose address lies in the special-function window produces a trap pulse in the next cycle, whatever the RAM-trap enable holds.
- R3: An opcode fetch whose address lies in the debug window produces a trap pulse in the next cycle, whatever the RAM-trap enable holds.
- R4: Writing control bit 7 only stages the RAM-trap enable. A RAM opcode fetch traps according to the enable last committed by command byte D2h, and a staged value has no effect until that commit.
- R5: Control bit 6 selects the trap output: 0 selects `irq_trap_o`, 1 selects `rst_req_o`. The new value applies to fetches in the cycles after the write, and the two outputs are never high together.
- R6: Command byte 4Eh gives a one-cycle `wdt_clr_o` pulse in the cycle after the write.
- R7: Command byte B1h gives a one-cycle `wdt_dis_o` pulse in the cycle after the write.
- R8: Any other command byte gives no watchdog strobe and does not commit the staged RAM-trap enable.
- R9: A cycle with `fetch_valid_i` low, or a fetch outside all three windows, produces no trap pulse.
- R10: Trapping fetches on consecutive cycles produce a pulse in each following cycle, with no suppression.
- R11: A fetch in the same cycle as a D2h commit is judged against the enable that was in force before the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | Current bus cycle is an opcode fetch |
| fetch_addr_i | input | ADDR_W | Fetch address |
| cfg_we_i | input | 1 | Write strobe for the control register |
| cmd_we_i | input | 1 | Write strobe for the command register |
| wdata_i | input | 8 | Write data shared by both registers |
| irq_trap_o | output | 1 | Non-maskable trap interrupt request pulse |
| rst_req_o | output | 1 | Trap reset request pulse |
| wdt_clr_o | output | 1 | Watchdog clear strobe |
| wdt_dis_o | output | 1 | Watchdog disable strobe |

## Verification
A trap from a fetch can fall in the same cycle as a command or control write. The bench sends a D2h commit, a 4Eh clear key and an action change together with trapping fetches in the same cycle. A scoreboard model compares each result: the fetch must be judged against the settings in force before the write, and a watchdog strobe and a trap pulse must both appear in the following cycle.

// File: rtl/fetch_trap_pkg.sv
package fetch_trap_pkg;
  localparam logic [7:0] KEY_COMMIT  = 8'hD2;
  localparam logic [7:0] KEY_WDT_CLR = 8'h4E;
  localparam logic [7:0] KEY_WDT_DIS = 8'hB1;
  localparam int CFG_RAM_BIT = 7;
  localparam int CFG_ACT_BIT = 6;
  localparam int NUM_WIN = 3;
  localparam int WIN_SFR = 0;
  localparam int WIN_DBG = 1;
  localparam int WIN_RAM = 2;

  typedef enum logic {ACT_IRQ = 1'b0, ACT_RST = 1'b1} trap_act_e;
endpackage

// File: rtl/ftc_region_match.sv
module ftc_region_match #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE  = '0,
  parameter logic [ADDR_W-1:0] LIMIT = '1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  // a zero base needs no lower compare
  if (BASE == '0) begin : g_zero_base
    assign hit_o = (addr_i <= LIMIT);
  end else begin : g_range
    assign hit_o = (addr_i >= BASE) && (addr_i <= LIMIT);
  end
endmodule

// File: rtl/ftc_key_dec.sv
module ftc_key_dec
  import fetch_trap_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_we_i,
  input  logic [7:0] wdata_i,
  output logic       commit_o,
  output logic       wdt_clr_o,
  output logic       wdt_dis_o
);
  logic clr_q, dis_q;

  assign commit_o = cmd_we_i && (wdata_i == KEY_COMMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_q <= 1'b0;
      dis_q <= 1'b0;
    end else begin
      clr_q <= cmd_we_i && (wdata_i == KEY_WDT_CLR);
      dis_q <= cmd_we_i && (wdata_i == KEY_WDT_DIS);
    end
  end

  assign wdt_clr_o = clr_q;
  assign wdt_dis_o = dis_q;

  a_r6_clr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_o |=> !wdt_clr_o || $past(cmd_we_i));
  a_r7_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wdt_clr_o, wdt_dis_o}));
endmodule

// File: rtl/ftc_cfg_regs.sv
module ftc_cfg_regs
  import fetch_trap_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cfg_we_i,
  input  logic      ram_bit_i,
  input  logic      act_bit_i,
  input  logic      commit_i,
  output logic      ram_en_o,
  output trap_act_e act_o
);
  logic      stage_q, ram_en_q;
  trap_act_e act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q  <= 1'b1;
      ram_en_q <= 1'b1;
      act_q    <= ACT_IRQ;
    end else begin
      if (cfg_we_i) begin
        stage_q <= ram_bit_i;
        act_q   <= trap_act_e'(act_bit_i);
      end
      // commit takes the value staged before this edge
      if (commit_i) ram_en_q <= stage_q;
    end
  end

  assign ram_en_o = ram_en_q;
  assign act_o    = act_q;

  a_r4_hold_without_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(ram_en_o));
  a_r5_act_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(act_o));
endmodule

// File: rtl/fetch_trap_ctrl.sv
module fetch_trap_ctrl
  import fetch_trap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SFR_BASE  = 16'h0000,
  parameter logic [ADDR_W-1:0] SFR_LIMIT = 16'h003F,
  parameter logic [ADDR_W-1:0] DBG_BASE  = 16'h0F80,
  parameter logic [ADDR_W-1:0] DBG_LIMIT = 16'h0FFF,
  parameter logic [ADDR_W-1:0] RAM_BASE  = 16'h0040,
  parameter logic [ADDR_W-1:0] RAM_LIMIT = 16'h083F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              cfg_we_i,
  input  logic              cmd_we_i,
  input  logic [7:0]        wdata_i,
  output logic              irq_trap_o,
  output logic              rst_req_o,
  output logic              wdt_clr_o,
  output logic              wdt_dis_o
);
  localparam logic [ADDR_W-1:0] WIN_BASE  [NUM_WIN] = '{SFR_BASE, DBG_BASE, RAM_BASE};
  localparam logic [ADDR_W-1:0] WIN_LIMIT [NUM_WIN] = '{SFR_LIMIT, DBG_LIMIT, RAM_LIMIT};

  logic [NUM_WIN-1:0] win_hit;
  logic               commit, ram_en, trap;
  trap_act_e          act;
  logic               irq_q, rst_q;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    ftc_region_match #(
      .ADDR_W(ADDR_W), .BASE(WIN_BASE[w]), .LIMIT(WIN_LIMIT[w])
    ) u_match (
      .addr_i(fetch_addr_i),
      .hit_o (win_hit[w])
    );
  end

  ftc_key_dec u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_we_i (cmd_we_i),
    .wdata_i  (wdata_i),
    .commit_o (commit),
    .wdt_clr_o(wdt_clr_o),
    .wdt_dis_o(wdt_dis_o)
  );

  ftc_cfg_regs u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_we_i (cfg_we_i),
    .ram_bit_i(wdata_i[CFG_RAM_BIT]),
    .act_bit_i(wdata_i[CFG_ACT_BIT]),
    .commit_i (commit),
    .ram_en_o (ram_en),
    .act_o    (act)
  );

  // special-function and debug windows trap unconditionally
  assign trap = fetch_valid_i &&
                (win_hit[WIN_SFR] || win_hit[WIN_DBG] || (win_hit[WIN_RAM] && ram_en));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      irq_q <= trap && (act == ACT_IRQ);
      rst_q <= trap && (act == ACT_RST);
    end
  end

  assign irq_trap_o = irq_q;
  assign rst_req_o  = rst_q;

  a_r2_sfr_always: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && win_hit[WIN_SFR]) |=> (irq_trap_o || rst_req_o));
  a_r3_dbg_always: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && win_hit[WIN_DBG]) |=> (irq_trap_o || rst_req_o));
  a_r5_one_action: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_trap_o && rst_req_o));
  a_r9_no_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |=> !(irq_trap_o || rst_req_o));
  a_r6_clr_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && wdata_i == KEY_WDT_CLR) |=> (wdt_clr_o && !wdt_dis_o));
  a_r7_dis_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && wdata_i == KEY_WDT_DIS) |=> (wdt_dis_o && !wdt_clr_o));
  a_r8_bad_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && wdata_i != KEY_WDT_CLR && wdata_i != KEY_WDT_DIS)
      |=> !(wdt_clr_o || wdt_dis_o));
endmodule

// File: tb/fetch_trap_ctrl_tb.sv
module fetch_trap_ctrl_tb;
  localparam int AW = 16;
  localparam logic [AW-1:0] A_SFR = 16'h0010;
  localparam logic [AW-1:0] A_DBG = 16'h0FA0;
  localparam logic [AW-1:0] A_RAM = 16'h0100;
  localparam logic [AW-1:0] A_ROM = 16'h2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fv = 1'b0, cfg_we = 1'b0, cmd_we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wd = '0;
  logic irq, rrq, clr, dis;

  always #5 clk = ~clk;

  fetch_trap_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_valid_i(fv), .fetch_addr_i(addr),
    .cfg_we_i(cfg_we), .cmd_we_i(cmd_we), .wdata_i(wd),
    .irq_trap_o(irq), .rst_req_o(rrq), .wdt_clr_o(clr), .wdt_dis_o(dis)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  logic [3:0] exp_q[$];
  string tag_q[$];

  // bench model of the programmable state
  logic m_stage = 1'b1, m_en = 1'b1, m_act = 1'b0;

  function automatic logic in_win(logic [AW-1:0] a, logic [AW-1:0] lo, logic [AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  task automatic step(input logic f, input logic [AW-1:0] a, input logic cw,
                      input logic kw, input logic [7:0] d, input string tag);
    logic trap;
    @(negedge clk);
    fv = f; addr = a; cfg_we = cw; cmd_we = kw; wd = d;
    trap = f && (in_win(a, 16'h0000, 16'h003F) || in_win(a, 16'h0F80, 16'h0FFF) ||
                 (in_win(a, 16'h0040, 16'h083F) && m_en));
    exp_q.push_back({trap && !m_act, trap && m_act, kw && d == 8'h4E, kw && d == 8'hB1});
    tag_q.push_back(tag);
    if (kw && d == 8'hD2) m_en = m_stage;
    if (cw) begin m_stage = d[7]; m_act = d[6]; end
  endtask

  // monitor: compares results after the edge that registers them
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({irq, rrq, clr, dis} !== e) begin
          failures++;
          $display("FAIL %s: {irq,rst,clr,dis} actual=%b expected=%b", t, {irq, rrq, clr, dis}, e);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if ({irq, rrq, clr, dis} !== 4'b0000) begin
      failures++;
      $display("FAIL R1: outputs in reset actual=%b expected=0000", {irq, rrq, clr, dis});
    end
    @(negedge clk);
    rst_n = 1'b1;

    step(1, A_RAM, 0, 0, 8'h00, "R1 reset enable traps RAM");
    step(1, A_ROM, 0, 0, 8'h00, "R9 outside windows");
    step(0, A_SFR, 0, 0, 8'h00, "R9 no fetch");
    step(1, A_SFR, 0, 0, 8'h00, "R2 sfr trap");
    step(1, A_DBG, 0, 0, 8'h00, "R3 R10 dbg back to back");
    step(0, A_ROM, 1, 0, 8'h00, "R4 stage zero");
    step(1, A_RAM, 0, 0, 8'h00, "R4 staged not live");
    step(0, A_ROM, 0, 1, 8'h55, "R8 bad key no strobe");
    step(1, A_RAM, 0, 0, 8'h00, "R8 bad key no commit");
    step(1, A_RAM, 0, 1, 8'hD2, "R11 fetch with commit");
    step(1, A_RAM, 0, 0, 8'h00, "R4 committed zero");
    step(1, A_SFR, 0, 0, 8'h00, "R2 sfr ignores enable");
    step(1, A_DBG, 0, 0, 8'h00, "R3 dbg ignores enable");
    step(0, A_ROM, 0, 1, 8'h4E, "R6 clear key");
    step(0, A_ROM, 0, 1, 8'hB1, "R7 disable key");
    step(1, A_SFR, 0, 1, 8'h4E, "R6 clear with trap");
    step(1, A_SFR, 1, 0, 8'h40, "R5 old action same cycle");
    step(1, A_SFR, 0, 0, 8'h00, "R5 reset request");
    step(1, A_DBG, 0, 0, 8'h00, "R5 R10 reset request dbg");
    step(1, A_RAM, 1, 0, 8'hC0, "R4 stage one");
    step(1, A_RAM, 0, 1, 8'hD2, "R11 commit one");
    step(1, A_RAM, 0, 0, 8'h00, "R4 committed one");
    step(0, A_ROM, 0, 1, 8'h00, "R8 zero key");
    step(1, A_RAM, 1, 0, 8'h80, "R5 back to irq");
    step(1, A_RAM, 0, 0, 8'h00, "R5 irq again");
    step(0, A_ROM, 0, 0, 8'h00, "R9 idle");
    step(0, A_ROM, 0, 0, 8'h00, "R9 idle");
    @(negedge clk);
    fv = 0; cfg_we = 0; cmd_we = 0;
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule